// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block gathers a small set of interrupt source lines, typically counter outputs or parallel port bits, into a status word and raises one interrupt request toward a host. Each source line is first brought into the block clock domain through a two-flop synchroniser. A rising edge then latches the source's status bit, but only while software has that source enabled. The bit stays set until software clears it.

There is no separate clear register. Software clears a status bit by turning off that source in the enable register. The bit drops on the same clock edge as the write, and the disable wins over a rising edge that arrives in that cycle.

The interrupt is a one-clock pulse, issued only when the status word as a whole leaves zero. A sticky pending flag rises with the pulse and holds until the status word is back to zero. A simple register bus gives software read and write access to the enable register and read access to the status word.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After a synchronous reset the enable register, the status word, `bus_rdata`, `irq_pulse` and `irq_pending` are all zero.
- R2: A rising edge on an enabled source sets its status bit on the third clock edge after the input changes (two synchroniser stages, then the latch). The bit stays set after the source falls again.
- R3: A rising edge on a disabled source sets nothing. A source that is already high when it becomes enabled sets nothing until it falls and rises again.
- R4: `irq_pulse` is high for exactly one clock, on the edge after the status word goes from zero to non-zero. It fires again after the word has returned to zero and a new bit is latched.
- R5: While the status word stays non-zero, no further `irq_pulse` occurs, even when more status bits become set.
- R6: `irq_pending` rises together with `irq_pulse`. It holds while any status bit is set and falls on the edge after the status word returns to zero.
- R7: A write that clears an enable bit clears the matching status bit on the same clock edge as the write, even if a rising edge on that source would latch in that cycle. Clearing some enables leaves the other status bits untouched.
- R8: On the register bus, address 0 is the read/write enable register (bit i enables source i). Address 1 is the read-only status word (bit i is source i), and writes to it are ignored. Addresses 2 and 3 read as zero. Data appears on `bus_rdata` on the clock edge that samples `bus_rd`. Bits at and above NUM_SRC are ignored on writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Asynchronous interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_pulse | output | 1 | One-clock interrupt request |
| irq_pending | output | 1 | Sticky flag, high while an interrupt is outstanding |

## Verification
The bench builds the block with its defaults: six sources, an 8-bit data bus and a 2-bit address. The two bus bits above the source field therefore exist, so the masking of wide writes and the zero read-back of unused bits can be observed. The 2-bit address also reaches both unmapped locations. The rising edge is timed cycle-exactly against the synchroniser depth, which lets the bench land a disable write on the very cycle the edge would latch.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned REG_ENABLE = 0;
  localparam int unsigned REG_STATUS = 1;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/isc_edge_sync.sv
module isc_edge_sync #(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [NUM_SRC-1:0] rise
);
  localparam int unsigned LAST = STAGES - 1;

  logic [NUM_SRC-1:0] prev_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        prev_q[g] <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], src_in[g]};
        prev_q[g] <= chain_q[LAST];
      end
    end

    assign rise[g] = chain_q[LAST] & ~prev_q[g];

    // R2: a detected edge lasts a single cycle
    p_rise_single_r2: assert property (@(posedge clk) disable iff (rst)
      rise[g] |=> !rise[g]);
  end
endmodule

// File: rtl/isc_regs.sv
module isc_regs
  import isc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] en_nxt,
  output logic [DATA_W-1:0]  bus_rdata
);
  localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(REG_ENABLE);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(REG_STATUS);

  logic              en_wr;
  logic [DATA_W-1:0] rd_word;

  assign en_wr  = bus_wr && (bus_addr == A_EN);
  assign en_nxt = en_wr ? bus_wdata[NUM_SRC-1:0] : en_q;

  always_comb begin
    rd_word = '0;
    if (bus_addr == A_EN)      rd_word[NUM_SRC-1:0] = en_q;
    else if (bus_addr == A_ST) rd_word[NUM_SRC-1:0] = status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      bus_rdata <= '0;
    end else begin
      en_q <= en_nxt;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end

  if (DATA_W > NUM_SRC) begin : g_upper
    // R8: bits above the source field never read back as one
    p_rdata_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
      bus_rdata[DATA_W-1:NUM_SRC] == '0);
  end

  // R8: read data only moves on a read strobe
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/isc_status.sv
module isc_status #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] rise,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic [NUM_SRC-1:0] en_nxt,
  output logic [NUM_SRC-1:0] status_q
);
  logic [NUM_SRC-1:0] status_nxt;

  // disable has priority: anything not enabled next cycle is dropped
  assign status_nxt = (status_q | (rise & en_q)) & en_nxt;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_nxt;
  end

  // R7: no status bit survives without its enable
  p_status_masked_r7: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~en_q) == '0);

  // R3: a bit can only appear for a source enabled in the prior cycle
  p_new_bit_enabled_r3: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~$past(status_q) & ~$past(en_q)) == '0));
endmodule

// File: rtl/isc_irq.sv
module isc_irq #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] status,
  output logic               irq_pulse,
  output logic               irq_pending
);
  logic any_set;
  logic any_set_q;

  assign any_set = |status;

  always_ff @(posedge clk) begin
    if (rst) begin
      any_set_q   <= 1'b0;
      irq_pulse   <= 1'b0;
      irq_pending <= 1'b0;
    end else begin
      any_set_q   <= any_set;
      irq_pulse   <= any_set & ~any_set_q;
      irq_pending <= any_set & (irq_pending | ~any_set_q);
    end
  end

  // R4: the request is a single-cycle pulse
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);

  // R4: a status word leaving zero is followed by a pulse
  p_pulse_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(any_set) |=> irq_pulse);

  // R5: nothing fires while an interrupt is outstanding
  p_no_refire_r5: assert property (@(posedge clk) disable iff (rst)
    irq_pending |=> !irq_pulse);

  // R6: the pending flag drops once the word is zero
  p_pending_drop_r6: assert property (@(posedge clk) disable iff (rst)
    !any_set |=> !irq_pending);
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import isc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_pulse,
  output logic               irq_pending
);
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] en_nxt;
  logic [NUM_SRC-1:0] status_q;

  isc_edge_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .src_in(src_in), .rise(rise)
  );

  isc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status(status_q),
    .en_q(en_q), .en_nxt(en_nxt), .bus_rdata(bus_rdata)
  );

  isc_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk(clk), .rst(rst), .rise(rise), .en_q(en_q), .en_nxt(en_nxt),
    .status_q(status_q)
  );

  isc_irq #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk(clk), .rst(rst), .status(status_q),
    .irq_pulse(irq_pulse), .irq_pending(irq_pending)
  );
endmodule

// File: tb/irq_latch_ctrl_bench.sv
module irq_latch_ctrl_bench;
  localparam int unsigned NS = 6;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_in = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_pulse;
  logic          irq_pending;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_latch_ctrl #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) u_irq_latch_ctrl (
    .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .irq_pending(irq_pending)
  );

  always @(negedge clk) if (!rst && irq_pulse) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input int addr, input int data);
    bus_addr = AW'(addr); bus_wdata = DW'(data); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int addr, output int data);
    bus_addr = AW'(addr); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    data = int'(bus_rdata);
  endtask

  task automatic t_reset;
    int v;
    rst = 1'b1;
    wait_n(3);
    chk("R1 rdata", int'(bus_rdata), 0);
    chk("R1 pulse", int'(irq_pulse), 0);
    chk("R1 pending", int'(irq_pending), 0);
    rst = 1'b0;
    wait_n(1);
    bus_read(0, v); chk("R1 enable", v, 0);
    bus_read(1, v); chk("R1 status", v, 0);
  endtask

  task automatic t_single_edge;
    int v;
    int p0;
    bus_write(0, 'h01);
    p0 = pulses;
    src_in[0] = 1'b1;
    wait_n(3);
    chk("R4 no pulse before latch", int'(irq_pulse), 0);
    wait_n(1);
    chk("R4 pulse after status", int'(irq_pulse), 1);
    chk("R6 pending with pulse", int'(irq_pending), 1);
    wait_n(1);
    chk("R4 pulse one cycle", int'(irq_pulse), 0);
    chk("R6 pending held", int'(irq_pending), 1);
    bus_read(1, v); chk("R2 status set", v, 'h01);
    src_in[0] = 1'b0;
    wait_n(5);
    bus_read(1, v); chk("R2 sticky after fall", v, 'h01);
    bus_write(0, 'h00);
    chk("R6 pending one more cycle", int'(irq_pending), 1);
    wait_n(1);
    chk("R6 pending cleared", int'(irq_pending), 0);
    bus_read(1, v); chk("R7 status cleared", v, 0);
    chk("R4 single pulse count", pulses - p0, 1);
  endtask

  task automatic t_disabled_edge;
    int v;
    int p0;
    p0 = pulses;
    src_in[1] = 1'b1;
    wait_n(6);
    bus_read(1, v); chk("R3 disabled edge ignored", v, 0);
    bus_write(0, 'h02);
    wait_n(6);
    bus_read(1, v); chk("R3 high level at enable ignored", v, 0);
    chk("R3 no pulse", pulses - p0, 0);
    src_in[1] = 1'b0;
    wait_n(4);
    src_in[1] = 1'b1;
    wait_n(5);
    bus_read(1, v); chk("R2 fresh edge latches", v, 'h02);
    bus_write(0, 'h00);
    src_in[1] = 1'b0;
    wait_n(4);
  endtask

  task automatic t_no_refire;
    int v;
    int p0;
    bus_write(0, 'h03);
    p0 = pulses;
    src_in[0] = 1'b1;
    wait_n(6);
    src_in[1] = 1'b1;
    wait_n(6);
    bus_read(1, v); chk("R5 both bits set", v, 'h03);
    chk("R5 only one pulse", pulses - p0, 1);
    // R7 partial clear keeps the other bit and the pending flag
    bus_write(0, 'h02);
    bus_read(1, v); chk("R7 partial clear", v, 'h02);
    chk("R6 pending kept on partial clear", int'(irq_pending), 1);
    chk("R5 no pulse on partial clear", pulses - p0, 1);
    bus_write(0, 'h00);
    wait_n(1);
    chk("R6 pending after full clear", int'(irq_pending), 0);
    src_in[0] = 1'b0;
    src_in[1] = 1'b0;
    wait_n(4);
    bus_write(0, 'h01);
    src_in[0] = 1'b1;
    wait_n(6);
    chk("R4 rearmed pulse", pulses - p0, 2);
    bus_write(0, 'h00);
    src_in[0] = 1'b0;
    wait_n(4);
  endtask

  task automatic t_disable_priority;
    int v;
    int p0;
    bus_write(0, 'h04);
    p0 = pulses;
    src_in[2] = 1'b1;
    wait_n(2);
    bus_write(0, 'h00);
    wait_n(3);
    bus_read(1, v); chk("R7 disable beats edge", v, 0);
    chk("R7 no pulse", pulses - p0, 0);
    chk("R7 no pending", int'(irq_pending), 0);
    src_in[2] = 1'b0;
    wait_n(4);
  endtask

  task automatic t_register_map;
    int v;
    bus_write(0, 'hFF);
    bus_read(0, v); chk("R8 enable masked", v, 'h3F);
    src_in[3] = 1'b1;
    wait_n(6);
    bus_write(1, 'h00);
    bus_read(1, v); chk("R8 status write ignored", v, 'h08);
    bus_write(1, 'hFF);
    bus_read(1, v); chk("R8 status write ones ignored", v, 'h08);
    bus_read(2, v); chk("R8 addr 2 zero", v, 0);
    bus_read(3, v); chk("R8 addr 3 zero", v, 0);
    bus_write(0, 'h00);
    src_in[3] = 1'b0;
    wait_n(4);
  endtask

  initial begin
    t_reset();
    t_single_edge();
    t_disabled_edge();
    t_no_refire();
    t_disable_priority();
    t_register_map();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule